// File: doc/BRIEF.md
# Serial Flow-Control Pin Sharing Logic

This block drives one device pin that is shared between a peripheral chip select and the hardware handshake of an asynchronous serial port. Two configuration bits choose what the pin shows. With flow control off, the pin carries the chip select, and that path is retimed to the bus clock. With flow control on, the pin carries one of two handshake levels, selected by a second bit. The first is a ready-to-send level, derived from whether the transmit register still holds data that has not gone out. The second is a ready-to-receive level, derived from whether the receive register is empty of unread data.

The handshake levels are combinational functions of the port status. They are not clocked, so the pin follows a status change within the same cycle. Once software reads the receive register, the serial logic clears its valid flag, and ready-to-receive then returns at once. The baud generator and the shifters are outside this block. Their state arrives here as two level signals.

Top module: `uart_fc_pin`

## Requirements
- R1: While `rst_n` is low, `pin_out` is 1, whatever the configuration and status inputs are.
- R2: With `fc_enable` = 0, `pin_out` equals the value `cs_n_in` had at the previous rising clock edge, a one-cycle registered delay.
- R3: With `fc_enable` = 1 and `rts_select` = 1, `pin_out` is 0 while `tx_pending` = 1 and is 1 while `tx_pending` = 0.
- R4: With `fc_enable` = 1 and `rts_select` = 0, `pin_out` is 0 while `rx_valid` = 0 and is 1 while `rx_valid` = 1. When a read clears `rx_valid`, the pin drops back to 0.
- R5: In either handshake function, `pin_out` responds to a status change within the same clock cycle, with no clock edge in between.
- R6: In the send function, `rx_valid` and `cs_n_in` have no effect on `pin_out`. In the receive function, `tx_pending` and `cs_n_in` have no effect on `pin_out`.
- R7: The chip select register keeps sampling `cs_n_in` while a handshake function is selected. On a return to `fc_enable` = 0, the pin at once shows the value sampled at the last edge.
- R8: The chip select register resets to 1, so after reset is released with `fc_enable` = 0, `pin_out` stays 1 until a 0 on `cs_n_in` has been sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low; also forces the pin high |
| cs_n_in | input | 1 | Peripheral chip select from the address decoder, active low |
| fc_enable | input | 1 | 1 = hardware flow control on for this port |
| rts_select | input | 1 | With flow control on: 1 = ready-to-send, 0 = ready-to-receive |
| tx_pending | input | 1 | Transmit register holds data not yet sent |
| rx_valid | input | 1 | Receive register holds valid unread data |
| pin_out | output | 1 | Shared pin level, active low for every function |

## Verification
Assertions check four properties on every clock edge. The pin is high during reset. In chip-select mode it matches the previous cycle's chip select. In each handshake mode it is the inverted or direct status level. Some behaviour can only be shown by the bench's scenarios. One part is the same-cycle response of the handshake levels between edges. Another is that the unselected inputs are ignored. The last part is the hand-back from a handshake function to the chip select, with the register still holding a fresh sample. The bench sets up each of these sequences and observes the pin.

// File: rtl/uart_fc_pkg.sv
// Shared definitions for the serial flow-control pin logic.
// Assumes nothing beyond a single pin with three possible functions.
package uart_fc_pkg;

    // Function currently routed to the shared pin.
    typedef enum logic [1:0] {
        FN_CHIP_SEL = 2'd0,
        FN_SEND     = 2'd1,
        FN_RECV     = 2'd2
    } pin_fn_e;

endpackage

// File: rtl/uart_fc_mode_dec.sv
// Decodes the two configuration bits into the function shown on the pin.
// Assumes both bits are static register outputs in the bus clock domain.
module uart_fc_mode_dec
    import uart_fc_pkg::*;
(
    input  logic    fc_enable,
    input  logic    rts_select,
    output pin_fn_e pin_fn
);

    // Flow-control enable decides first; the mode bit only matters when it is set.
    always_comb begin
        if (!fc_enable)
            pin_fn = FN_CHIP_SEL;
        else if (rts_select)
            pin_fn = FN_SEND;
        else
            pin_fn = FN_RECV;
    end

endmodule

// File: rtl/uart_fc_cs_sync.sv
// Registers the peripheral chip select on the bus clock so the pin's
// chip-select function is synchronous. It samples on every edge, whatever
// the pin shows. Assumes an active-low select idle at RESET_LEVEL.
module uart_fc_cs_sync #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    output logic cs_n_q
);

    // One-flop retiming of the chip select, cleared to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_n_q <= RESET_LEVEL;
        else
            cs_n_q <= cs_n_in;
    end

endmodule

// File: rtl/uart_fc_handshake.sv
// Produces ready-to-send and ready-to-receive levels straight from the port
// status, with no clock. Assumes status levels are glitch-free register outputs.
module uart_fc_handshake #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic tx_pending,
    input  logic rx_valid,
    output logic send_lvl,
    output logic recv_lvl
);

    localparam logic ASSERTED = ACTIVE_LOW ? 1'b0 : 1'b1;

    // Send is asserted while unsent data waits; receive while the buffer is empty.
    always_comb begin
        send_lvl = tx_pending ? ASSERTED : ~ASSERTED;
        recv_lvl = rx_valid   ? ~ASSERTED : ASSERTED;
    end

endmodule

// File: rtl/uart_fc_pin.sv
// Shared pin for peripheral chip select and serial hardware handshake.
// Routes the registered chip select, the send level or the receive level
// to the pin, and forces the pin high during reset. Assumes rst_n is
// synchronous to clk and that configuration bits change only between accesses.
module uart_fc_pin
    import uart_fc_pkg::*;
#(
    parameter bit   HS_ACTIVE_LOW = 1'b1,
    parameter logic RESET_PIN     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic fc_enable,
    input  logic rts_select,
    input  logic tx_pending,
    input  logic rx_valid,
    output logic pin_out
);

    pin_fn_e pin_fn;
    logic    cs_n_q;
    logic    send_lvl;
    logic    recv_lvl;
    logic    fn_lvl;

    uart_fc_mode_dec u_dec (
        .fc_enable  (fc_enable),
        .rts_select (rts_select),
        .pin_fn     (pin_fn)
    );

    uart_fc_cs_sync #(.RESET_LEVEL(RESET_PIN)) u_cs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_in (cs_n_in),
        .cs_n_q  (cs_n_q)
    );

    uart_fc_handshake #(.ACTIVE_LOW(HS_ACTIVE_LOW)) u_hs (
        .tx_pending (tx_pending),
        .rx_valid   (rx_valid),
        .send_lvl   (send_lvl),
        .recv_lvl   (recv_lvl)
    );

    // Select the level that belongs to the active pin function.
    always_comb begin
        unique case (pin_fn)
            FN_SEND: fn_lvl = send_lvl;
            FN_RECV: fn_lvl = recv_lvl;
            default: fn_lvl = cs_n_q;
        endcase
    end

    // Hold the pin at its idle level whenever reset is active.
    always_comb begin
        pin_out = rst_n ? fn_lvl : RESET_PIN;
    end

    // Reset keeps the pin idle (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (pin_out == RESET_PIN)
                else $error("pin not idle during reset");
        end
    end

    // Chip-select mode shows the previous cycle's select (R2).
    assert_cs_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc_enable && $past(rst_n)) |-> (pin_out == $past(cs_n_in)))
        else $error("chip select not delayed by one cycle");

    // Send mode follows the transmit status (R3).
    assert_send_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_enable && rts_select) |-> (pin_out == (HS_ACTIVE_LOW ? !tx_pending : tx_pending)))
        else $error("send level wrong");

    // Receive mode follows the receive status (R4).
    assert_recv_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_enable && !rts_select) |-> (pin_out == (HS_ACTIVE_LOW ? rx_valid : !rx_valid)))
        else $error("receive level wrong");

endmodule

// File: tb/uart_fc_pin_tb.sv
`timescale 1ns/1ps
module uart_fc_pin_tb;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n_in = 1'b1;
    logic fc_enable = 1'b0;
    logic rts_select = 1'b0;
    logic tx_pending = 1'b0;
    logic rx_valid = 1'b0;
    logic pin_out;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    item_t q[$];
    event chk_ev;

    always #2.5 clk = ~clk;

    uart_fc_pin u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_in    (cs_n_in),
        .fc_enable  (fc_enable),
        .rts_select (rts_select),
        .tx_pending (tx_pending),
        .rx_valid   (rx_valid),
        .pin_out    (pin_out)
    );

    // Monitor: pops expected items and compares them with the pin.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (pin_out !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: pin_out=%b expected=%b", it.tag, pin_out, it.exp);
                end
            end
        end
    end

    // Driver side: settle, then queue the expected pin level.
    task automatic expect_pin(input logic e, input string tag);
        item_t it;
        #1;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        ->chk_ev;
        #0.1;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset forces the pin high in every function
        fc_enable = 1'b0; cs_n_in = 1'b0;
        next_cycle(); expect_pin(1'b1, "R1 reset chip-select mode");
        fc_enable = 1'b1; rts_select = 1'b1; tx_pending = 1'b1;
        expect_pin(1'b1, "R1 reset send mode");
        rts_select = 1'b0; rx_valid = 1'b0;
        expect_pin(1'b1, "R1 reset receive mode");

        // R8: after release, chip select register holds idle 1
        next_cycle();
        fc_enable = 1'b0; cs_n_in = 1'b1; tx_pending = 1'b0;
        rst_n = 1'b1;
        expect_pin(1'b1, "R8 idle after reset");
        next_cycle(); expect_pin(1'b1, "R8 idle with cs high");

        // R2: one-cycle registered delay
        cs_n_in = 1'b0;
        expect_pin(1'b1, "R2 before edge");
        next_cycle(); expect_pin(1'b0, "R2 after edge low");
        cs_n_in = 1'b1;
        next_cycle(); expect_pin(1'b1, "R2 after edge high");

        // R3/R5: send mode, same-cycle response
        fc_enable = 1'b1; rts_select = 1'b1; tx_pending = 1'b1;
        expect_pin(1'b0, "R3 R5 tx pending");
        tx_pending = 1'b0;
        expect_pin(1'b1, "R3 R5 tx drained");
        // R6: receive status and chip select ignored in send mode
        rx_valid = 1'b1; cs_n_in = 1'b0;
        expect_pin(1'b1, "R6 send ignores rx_valid");
        next_cycle(); expect_pin(1'b1, "R6 send ignores cs");
        tx_pending = 1'b1; rx_valid = 1'b0;
        expect_pin(1'b0, "R6 send ignores rx change");

        // R4: receive mode
        rts_select = 1'b0; rx_valid = 1'b0;
        expect_pin(1'b0, "R4 buffer empty");
        rx_valid = 1'b1;
        expect_pin(1'b1, "R4 data waiting");
        next_cycle();
        rx_valid = 1'b0;
        expect_pin(1'b0, "R4 R5 read clears valid");
        // R6: transmit status and chip select ignored in receive mode
        tx_pending = 1'b0; cs_n_in = 1'b1;
        expect_pin(1'b0, "R6 recv ignores tx");
        next_cycle(); expect_pin(1'b0, "R6 recv ignores cs");

        // R7: register kept sampling; hand back shows latest sample
        cs_n_in = 1'b0;
        next_cycle();
        fc_enable = 1'b0;
        expect_pin(1'b0, "R7 hand-back shows sample");
        cs_n_in = 1'b1;
        expect_pin(1'b0, "R7 still old sample");
        next_cycle(); expect_pin(1'b1, "R7 new sample");

        // R1: reset mid-operation in send mode
        fc_enable = 1'b1; rts_select = 1'b1; tx_pending = 1'b1;
        expect_pin(1'b0, "R3 before reset");
        rst_n = 1'b0;
        expect_pin(1'b1, "R1 reset during send");
        next_cycle(); expect_pin(1'b1, "R1 reset held");

        next_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule